// File: doc/BRIEF.md
# AUX Transaction Retry Sequencer

This controller carries a single DisplayPort AUX command, either a native access or an I2C-over-AUX access, from acceptance to a final verdict. A host hands it a command: the address space, the direction, whether more commands of the same I2C transfer follow, the address and the byte length. The sequencer then issues channel requests to a downstream framer. After each request it takes one classified outcome from a reply decoder and chooses what happens next. It can reissue the request, wait first, continue a partial read, turn a write into a status poll, or stop with a verdict.

Each kind of trouble has its own retry budget: malformed replies, channel timeouts, AUX-level defers, I2C-level defers, short read acknowledgements and partial write acknowledgements. The microsecond waits between retries come from a free-running divided tick. For I2C-over-AUX, the block closes the bus with a zero-length request that has the more-to-come bit cleared. It does this when the command is the last one of the transfer or when the command has failed. The stop's own outcome never replaces the verdict. The verdict is held for the host until the host acknowledges it.

Top module: `auxtx_retry_seq`

## Requirements
- R1: After reset `cmd_ready` is high and `req_valid` and `done_valid` are low. A command is taken only while `cmd_ready` is high, and `cmd_valid` asserted at any other time changes no request field and no verdict.
- R2: Request command nibble `req_action`: native read 4'b1001, native write 4'b1000, I2C main request {1'b0, more-to-come 1, 1'b0, read}, I2C write status poll {1'b0, more-to-come, 2'b10}. For I2C, `req_addr` is `cmd_addr[7:1]`; for native it is `cmd_addr`. The first request carries `cmd_len` at offset 0. Request fields hold steady while `req_valid` waits for `req_ready`.
- R3: Outcome INVALID (code 6) is retried after a wait of INV_WAIT_US microseconds. The second consecutive INVALID ends the command with verdict PROTO (3).
- R4: Outcome TIMEOUT (code 5) is retried with no wait. The third consecutive TIMEOUT ends the command with verdict TIMEOUT (2).
- R5: Outcome DEFER (code 2) is retried. Reads fail with TIMEOUT on the 7th consecutive DEFER. Writes fail on the (L+1)th, where L is the larger of WR_DEFER_MAX and 6. The same limits apply to I2C_DEFER (code 3).
- R6: On ACK (code 0) to a read, `rsp_count` above the remaining length gives PROTO, and equal gives OK (0). If it is lower, the request is reissued with the remaining length reduced and `req_offset` advanced by `rsp_count`. A second such shortfall gives PROTO.
- R7: On ACK to an I2C write with nonzero `rsp_count`, the request becomes a zero-length status poll that keeps the more-to-come bit. It is retried after ACKM_WAIT_US microseconds, and the 7th such ACK gives TIMEOUT. ACK with a zero count, or ACK to any native write, gives OK.
- R8: I2C_DEFER on a write turns the request into a zero-length status poll. I2C_DEFER clears the AUX defer budget.
- R9: NACK (1) and I2C_NACK (4) end the command at once with verdict NACK (1). HPD (7) ends it at once with verdict HPD (4).
- R10: An I2C command whose `cmd_mot` is low, or that failed, is followed by one zero-length request with action {2'b00, 1'b0, read}. That request has its own retries, and the verdict stays that of the main command. Native commands are never followed by a stop.
- R11: Each I2C retry waits I2C_GAP_US microseconds in addition to any other wait.
- R12: `done_valid` and `done_status` hold until `done_ack`, after which `cmd_ready` returns.
- R13: A non-error channel outcome (ACK, NACK, DEFER, I2C_DEFER, I2C_NACK) clears the timeout and invalid budgets. An ACK clears the AUX defer budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Sequencer idle and taking commands |
| cmd_i2c | input | 1 | 1: I2C-over-AUX, 0: native |
| cmd_write | input | 1 | 1: write, 0: read |
| cmd_mot | input | 1 | More commands of this I2C transfer follow |
| cmd_addr | input | ADDR_W | Native address or 8-bit I2C device address |
| cmd_len | input | LEN_W | Payload byte count |
| req_valid | output | 1 | Channel request pending |
| req_ready | input | 1 | Framer takes the request |
| req_action | output | 4 | Command nibble |
| req_addr | output | ADDR_W | Request address |
| req_len | output | LEN_W | Remaining byte count |
| req_offset | output | LEN_W | Buffer offset for read continuation |
| rsp_valid | input | 1 | Classified outcome present |
| rsp_outcome | input | 3 | Outcome code |
| rsp_count | input | LEN_W | Data bytes returned |
| done_valid | output | 1 | Verdict available |
| done_status | output | 3 | Verdict: 0 OK, 1 NACK, 2 TIMEOUT, 3 PROTO, 4 HPD |
| done_ack | input | 1 | Host takes the verdict |

## Verification
The bench sweeps each budget across its limit, one retry on either side. A budget off by one would pass a command that should fail, or fail one that should pass. It interleaves outcomes, for example timeouts, then a short ACK, then more timeouts. A design that never clears its counters on a good outcome would fail those commands. The bench measures the gap between each outcome and the next request to catch waits that are skipped, misplaced or missing the I2C gap. It also checks stop generation and stop fields. A wrong stop rule would show up as a stray or missing final request, or as a verdict overwritten by the stop's outcome.

// File: rtl/auxtx_pkg.sv
package auxtx_pkg;
   // channel outcome codes from the reply decoder
   localparam logic [2:0] OC_ACK       = 3'd0;
   localparam logic [2:0] OC_NACK      = 3'd1;
   localparam logic [2:0] OC_DEFER     = 3'd2;
   localparam logic [2:0] OC_I2C_DEFER = 3'd3;
   localparam logic [2:0] OC_I2C_NACK  = 3'd4;
   localparam logic [2:0] OC_TIMEOUT   = 3'd5;
   localparam logic [2:0] OC_INVALID   = 3'd6;
   localparam logic [2:0] OC_HPD       = 3'd7;

   // verdict codes
   localparam logic [2:0] VD_OK      = 3'd0;
   localparam logic [2:0] VD_NACK    = 3'd1;
   localparam logic [2:0] VD_TIMEOUT = 3'd2;
   localparam logic [2:0] VD_PROTO   = 3'd3;
   localparam logic [2:0] VD_HPD     = 3'd4;

   // budget slots
   localparam int NB     = 6;
   localparam int B_INV  = 0;
   localparam int B_TMO  = 1;
   localparam int B_ADEF = 2;
   localparam int B_IDEF = 3;
   localparam int B_SHRT = 4;
   localparam int B_ACKM = 5;

   typedef enum logic [2:0] {
      S_IDLE, S_ISSUE, S_WAIT, S_PAUSE, S_DONE
   } seq_state_e;
endpackage

// File: rtl/auxtx_budget.sv
module auxtx_budget #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit,
   output logic             spent
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (clr)              cnt <= '0;
      else if (inc && cnt != '1) cnt <= cnt + 1'b1;
   end

   // the next increment would exceed the limit
   assign spent = (cnt >= limit);

   p_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);
   p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt == '1) |=> cnt == '1);
endmodule

// File: rtl/auxtx_us_timer.sv
module auxtx_us_timer #(
   parameter int CLK_PER_US = 100,
   parameter int US_W       = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [US_W-1:0] load_us,
   output logic            busy
);
   logic            tick;
   logic [US_W-1:0] rem;

   generate
      if (CLK_PER_US < 1) begin : g_bad
         $error("auxtx_us_timer: CLK_PER_US must be at least 1");
      end
      if (CLK_PER_US == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DIV_W = $clog2(CLK_PER_US);
         logic [DIV_W-1:0] div;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   div <= '0;
            else if (div == DIV_W'(CLK_PER_US - 1))       div <= '0;
            else                                          div <= div + 1'b1;
         end
         assign tick = (div == DIV_W'(CLK_PER_US - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  rem <= '0;
      else if (load)               rem <= load_us;
      else if (tick && rem != '0)  rem <= rem - 1'b1;
   end

   assign busy = (rem != '0);

   p_load_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_us != '0) |=> busy);
endmodule

// File: rtl/auxtx_retry_seq.sv
module auxtx_retry_seq
   import auxtx_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int LEN_W        = 5,
   parameter int CNT_W        = 4,
   parameter int CLK_PER_US   = 100,
   parameter int INV_WAIT_US  = 400,
   parameter int ACKM_WAIT_US = 300,
   parameter int I2C_GAP_US   = 0,
   parameter int INV_LIMIT    = 1,
   parameter int TMO_LIMIT    = 2,
   parameter int DEFER_LIMIT  = 6,
   parameter int SHORT_LIMIT  = 1,
   parameter int WR_DEFER_MAX = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_i2c,
   input  logic              cmd_write,
   input  logic              cmd_mot,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_len,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [3:0]        req_action,
   output logic [ADDR_W-1:0] req_addr,
   output logic [LEN_W-1:0]  req_len,
   output logic [LEN_W-1:0]  req_offset,
   input  logic              rsp_valid,
   input  logic [2:0]        rsp_outcome,
   input  logic [LEN_W-1:0]  rsp_count,
   output logic              done_valid,
   output logic [2:0]        done_status,
   input  logic              done_ack
);
   localparam int WR_DEFER_LIMIT = (WR_DEFER_MAX > DEFER_LIMIT) ? WR_DEFER_MAX : DEFER_LIMIT;
   localparam int WAIT_SUM       = INV_WAIT_US + ACKM_WAIT_US + I2C_GAP_US;
   localparam int US_W           = $clog2(WAIT_SUM + 2);

   generate
      if (ADDR_W < 8)  begin : g_bad_addr $error("auxtx_retry_seq: ADDR_W below 8"); end
      if (LEN_W < 1)   begin : g_bad_len  $error("auxtx_retry_seq: LEN_W below 1"); end
      if ((1 << CNT_W) <= WR_DEFER_LIMIT + 1) begin : g_bad_cnt
         $error("auxtx_retry_seq: CNT_W too narrow for the retry limits");
      end
   endgenerate

   seq_state_e        st;
   logic              c_i2c, c_write, c_mot, in_stop;
   logic [3:0]        act;
   logic [ADDR_W-1:0] addr;
   logic [LEN_W-1:0]  rem, off;
   logic [2:0]        verdict;

   // per-outcome decision
   logic              decide, term, need_stop, accept, clr_all;
   logic [2:0]        term_st;
   logic [3:0]        nx_act;
   logic [LEN_W-1:0]  nx_rem, nx_off;
   logic [US_W-1:0]   base_wait, load_us;
   logic [NB-1:0]     inc_v, clr_v, clr_sel, exc;
   logic [CNT_W-1:0]  lim [NB];
   logic              tmr_busy;
   logic [3:0]        poll_act;

   assign accept   = (st == S_IDLE) && cmd_valid;
   assign decide   = (st == S_WAIT) && rsp_valid;
   assign poll_act = {1'b0, act[2], 2'b10};

   always_comb begin
      for (int b = 0; b < NB; b++) lim[b] = '0;
      lim[B_INV]  = CNT_W'(INV_LIMIT);
      lim[B_TMO]  = CNT_W'(TMO_LIMIT);
      lim[B_ADEF] = c_write ? CNT_W'(WR_DEFER_LIMIT) : CNT_W'(DEFER_LIMIT);
      lim[B_IDEF] = c_write ? CNT_W'(WR_DEFER_LIMIT) : CNT_W'(DEFER_LIMIT);
      lim[B_SHRT] = CNT_W'(SHORT_LIMIT);
      lim[B_ACKM] = CNT_W'(DEFER_LIMIT);
   end

   always_comb begin
      inc_v     = '0;
      clr_sel   = '0;
      term      = 1'b0;
      term_st   = VD_OK;
      nx_act    = act;
      nx_rem    = rem;
      nx_off    = off;
      base_wait = '0;
      if (decide) begin
         case (rsp_outcome)
            OC_TIMEOUT: begin
               inc_v[B_TMO] = 1'b1;
               if (exc[B_TMO]) begin term = 1'b1; term_st = VD_TIMEOUT; end
            end
            OC_INVALID: begin
               inc_v[B_INV] = 1'b1;
               base_wait    = US_W'(INV_WAIT_US);
               if (exc[B_INV]) begin term = 1'b1; term_st = VD_PROTO; end
            end
            OC_HPD: begin
               term = 1'b1; term_st = VD_HPD;
            end
            default: begin
               clr_sel[B_TMO] = 1'b1;
               clr_sel[B_INV] = 1'b1;
               case (rsp_outcome)
                  OC_ACK: begin
                     clr_sel[B_ADEF] = 1'b1;
                     if (!c_write) begin
                        if (rsp_count > rem) begin
                           term = 1'b1; term_st = VD_PROTO;
                        end else if (rsp_count == rem) begin
                           term = 1'b1; term_st = VD_OK;
                        end else begin
                           inc_v[B_SHRT] = 1'b1;
                           nx_rem = rem - rsp_count;
                           nx_off = off + rsp_count;
                           if (exc[B_SHRT]) begin term = 1'b1; term_st = VD_PROTO; end
                        end
                     end else if (c_i2c && rsp_count != '0) begin
                        inc_v[B_ACKM] = 1'b1;
                        nx_act        = poll_act;
                        nx_rem        = '0;
                        base_wait     = US_W'(ACKM_WAIT_US);
                        if (exc[B_ACKM]) begin term = 1'b1; term_st = VD_TIMEOUT; end
                     end else begin
                        term = 1'b1; term_st = VD_OK;
                     end
                  end
                  OC_DEFER: begin
                     inc_v[B_ADEF] = 1'b1;
                     if (exc[B_ADEF]) begin term = 1'b1; term_st = VD_TIMEOUT; end
                  end
                  OC_I2C_DEFER: begin
                     clr_sel[B_ADEF] = 1'b1;
                     inc_v[B_IDEF]   = 1'b1;
                     if (c_write) begin
                        nx_act = poll_act;
                        nx_rem = '0;
                     end
                     if (exc[B_IDEF]) begin term = 1'b1; term_st = VD_TIMEOUT; end
                  end
                  default: begin
                     term = 1'b1; term_st = VD_NACK;
                  end
               endcase
            end
         endcase
      end
   end

   assign need_stop = !in_stop && c_i2c && (!c_mot || term_st != VD_OK);
   assign clr_all   = accept || (decide && term && need_stop);
   assign clr_v     = clr_sel | {NB{clr_all}};
   assign load_us   = base_wait + (c_i2c ? US_W'(I2C_GAP_US) : US_W'(0));

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bud
         auxtx_budget #(.CNT_W(CNT_W)) u_bud (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_v[b]),
            .inc   (inc_v[b]),
            .limit (lim[b]),
            .spent (exc[b])
         );
      end
   endgenerate

   auxtx_us_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (decide && !term),
      .load_us (load_us),
      .busy    (tmr_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         c_i2c   <= 1'b0;
         c_write <= 1'b0;
         c_mot   <= 1'b0;
         in_stop <= 1'b0;
         act     <= '0;
         addr    <= '0;
         rem     <= '0;
         off     <= '0;
         verdict <= VD_OK;
      end else begin
         case (st)
            S_IDLE: if (cmd_valid) begin
               c_i2c   <= cmd_i2c;
               c_write <= cmd_write;
               c_mot   <= cmd_mot;
               in_stop <= 1'b0;
               act     <= cmd_i2c ? {2'b01, 1'b0, !cmd_write} : {3'b100, !cmd_write};
               addr    <= cmd_i2c ? ADDR_W'(cmd_addr[7:1]) : cmd_addr;
               rem     <= cmd_len;
               off     <= '0;
               st      <= S_ISSUE;
            end
            S_ISSUE: if (req_ready) st <= S_WAIT;
            S_WAIT: if (rsp_valid) begin
               if (term) begin
                  if (need_stop) begin
                     in_stop <= 1'b1;
                     verdict <= term_st;
                     act     <= {3'b000, !c_write};
                     rem     <= '0;
                     off     <= '0;
                     st      <= S_ISSUE;
                  end else begin
                     if (!in_stop) verdict <= term_st;
                     st <= S_DONE;
                  end
               end else begin
                  act <= nx_act;
                  rem <= nx_rem;
                  off <= nx_off;
                  st  <= S_PAUSE;
               end
            end
            S_PAUSE: if (!tmr_busy) st <= S_ISSUE;
            S_DONE:  if (done_ack)  st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign cmd_ready   = (st == S_IDLE);
   assign req_valid   = (st == S_ISSUE);
   assign req_action  = act;
   assign req_addr    = addr;
   assign req_len     = rem;
   assign req_offset  = off;
   assign done_valid  = (st == S_DONE);
   assign done_status = verdict;

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!req_valid && !done_valid));
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_action)
                                     && $stable(req_addr) && $stable(req_len)));
   p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_ack) |=> (done_valid && $stable(done_status)));
   p_stop_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && in_stop) |-> (req_len == '0 && req_action[3:2] == 2'b00));
   p_native_nostop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_action[3]) |-> !in_stop);
endmodule

// File: tb/auxtx_retry_seq_tb.sv
`timescale 1ns/1ps
module auxtx_retry_seq_tb;
   localparam int CPU = 4;
   localparam int GAP = 3;
   localparam int WRL = 8;   // larger of WR_DEFER_MAX (8) and 6

   localparam logic [2:0] O_ACK = 0, O_NACK = 1, O_DEF = 2, O_IDEF = 3,
                          O_INACK = 4, O_TMO = 5, O_INV = 6, O_HPD = 7;
   localparam logic [2:0] V_OK = 0, V_NACK = 1, V_TMO = 2, V_PROTO = 3, V_HPD = 4;

   logic clk = 0, rst_n = 0;
   logic cmd_valid = 0, cmd_i2c = 0, cmd_write = 0, cmd_mot = 0;
   logic [19:0] cmd_addr = 0;
   logic [4:0]  cmd_len = 0;
   logic req_ready = 0, rsp_valid = 0, done_ack = 0;
   logic [2:0] rsp_outcome = 0;
   logic [4:0] rsp_count = 0;
   logic cmd_ready, req_valid, done_valid;
   logic [3:0] req_action;
   logic [19:0] req_addr;
   logic [4:0] req_len, req_offset;
   logic [2:0] done_status;

   always #10 clk = ~clk;

   auxtx_retry_seq #(.CLK_PER_US(CPU), .I2C_GAP_US(GAP), .WR_DEFER_MAX(WRL)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_i2c(cmd_i2c), .cmd_write(cmd_write), .cmd_mot(cmd_mot),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .req_valid(req_valid),
      .req_ready(req_ready), .req_action(req_action), .req_addr(req_addr),
      .req_len(req_len), .req_offset(req_offset), .rsp_valid(rsp_valid),
      .rsp_outcome(rsp_outcome), .rsp_count(rsp_count), .done_valid(done_valid),
      .done_status(done_status), .done_ack(done_ack));

   int nchk = 0, nerr = 0, cyc = 0;
   bit finished = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [2:0] sc_out [0:31];
   logic [4:0] sc_cnt [0:31];
   int sc_n;
   logic [3:0]  r_act  [0:47];
   logic [19:0] r_addr [0:47];
   logic [4:0]  r_len  [0:47];
   logic [4:0]  r_off  [0:47];
   int          r_gap  [0:47];
   int nreq;
   logic [2:0] got;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic fill(input int from, input int n, input logic [2:0] o, input logic [4:0] c);
      for (int i = from; i < from + n; i++) begin sc_out[i] = o; sc_cnt[i] = c; end
      if (from + n > sc_n) sc_n = from + n;
   endtask

   task automatic run(input bit i2c, input bit wr, input bit mot,
                      input logic [19:0] a, input logic [4:0] l, input bit noise);
      int last = 0;
      nreq = 0;
      @(negedge clk);
      cmd_valid = 1; cmd_i2c = i2c; cmd_write = wr; cmd_mot = mot;
      cmd_addr = a; cmd_len = l;
      @(negedge clk);
      if (noise) begin
         cmd_i2c = !i2c; cmd_write = !wr; cmd_addr = 20'h7777; cmd_len = 5'd9;
      end else cmd_valid = 0;
      while (!done_valid && nreq < 48) begin
         if (req_valid) begin
            r_act[nreq] = req_action; r_addr[nreq] = req_addr;
            r_len[nreq] = req_len;    r_off[nreq] = req_offset;
            r_gap[nreq] = cyc - last;
            req_ready = 1;
            @(negedge clk); req_ready = 0;
            @(negedge clk);
            rsp_valid = 1;
            if (nreq < sc_n) begin
               rsp_outcome = sc_out[nreq]; rsp_count = sc_cnt[nreq];
            end else begin
               rsp_outcome = O_ACK; rsp_count = wr ? 5'd0 : r_len[nreq];
            end
            nreq++;
            @(negedge clk); rsp_valid = 0;
            last = cyc;
         end else @(negedge clk);
      end
      cmd_valid = 0;
      got = done_status;
   endtask

   task automatic finish_cmd;
      done_ack = 1;
      @(negedge clk); done_ack = 0;
      sc_n = 0;
   endtask

   task automatic expect_end(input logic [2:0] st, input int n, input string tag);
      chk(got == st, {tag, " verdict"}, got, st);
      chk(nreq == n, {tag, " request count"}, nreq, n);
      finish_cmd();
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      if (!finished) begin
         nerr++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      sc_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(cmd_ready == 1, "R1 ready after reset", cmd_ready, 1);
      chk(req_valid == 0, "R1 no request after reset", req_valid, 0);
      chk(done_valid == 0, "R1 no verdict after reset", done_valid, 0);

      // R2 R1 R12: native read, full ACK, with command noise while busy
      fill(0, 1, O_ACK, 5'd4);
      run(0, 0, 0, 20'h12345, 5'd4, 1);
      chk(r_act[0] == 4'b1001, "R2 native read action", r_act[0], 9);
      chk(r_addr[0] == 20'h12345, "R2 native address", r_addr[0], 20'h12345);
      chk(r_len[0] == 5'd4 && r_off[0] == 0, "R2 first length/offset", r_len[0], 4);
      repeat (3) @(negedge clk);
      chk(done_valid == 1 && done_status == got, "R12 verdict held", done_valid, 1);
      expect_end(V_OK, 1, "R1 busy command ignored");
      chk(cmd_ready == 1, "R12 ready after ack", cmd_ready, 1);
      repeat (3) @(negedge clk);
      chk(req_valid == 0, "R1 no stray request", req_valid, 0);

      // R6 short read continuation
      fill(0, 2, O_ACK, 5'd2);
      run(0, 0, 0, 20'h00040, 5'd4, 0);
      chk(r_len[1] == 2 && r_off[1] == 2, "R6 continuation len/off", r_len[1], 2);
      expect_end(V_OK, 2, "R6 one shortfall");
      fill(0, 2, O_ACK, 5'd1);
      run(0, 0, 0, 20'h00040, 5'd4, 0);
      expect_end(V_PROTO, 2, "R6 two shortfalls");
      fill(0, 1, O_ACK, 5'd5);
      run(0, 0, 0, 20'h00040, 5'd4, 0);
      expect_end(V_PROTO, 1, "R6 over-count");

      // R5 native read defer sweep
      for (int n = 0; n <= 7; n++) begin
         fill(0, n, O_DEF, 5'd0);
         run(0, 0, 0, 20'h00100, 5'd2, 0);
         if (n <= 6) expect_end(V_OK, n + 1, "R5 read defers");
         else        expect_end(V_TMO, 7, "R5 read defer limit");
      end
      // R5 native write defer sweep (limit 8)
      for (int n = 8; n <= 9; n++) begin
         fill(0, n, O_DEF, 5'd0);
         run(0, 1, 0, 20'h00100, 5'd1, 0);
         if (n == 8) expect_end(V_OK, 9, "R5 write defers");
         else        expect_end(V_TMO, 9, "R5 write defer limit");
      end

      // R4 timeout sweep, immediate retry
      for (int n = 0; n <= 3; n++) begin
         fill(0, n, O_TMO, 5'd0);
         run(0, 0, 0, 20'h00200, 5'd1, 0);
         if (n >= 1) chk(r_gap[1] <= 6, "R4 timeout retry without wait", r_gap[1], 6);
         if (n <= 2) expect_end(V_OK, n + 1, "R4 timeouts");
         else        expect_end(V_TMO, 3, "R4 timeout limit");
      end

      // R3 invalid replies with 400 us wait
      for (int n = 0; n <= 2; n++) begin
         fill(0, n, O_INV, 5'd0);
         run(0, 0, 0, 20'h00300, 5'd1, 0);
         if (n == 1) chk(r_gap[1] >= 399 * CPU && r_gap[1] <= 400 * CPU + 6,
                         "R3 invalid wait", r_gap[1], 400 * CPU);
         if (n <= 1) expect_end(V_OK, n + 1, "R3 invalid");
         else        expect_end(V_PROTO, 2, "R3 invalid limit");
      end

      // R13 counters cleared by good outcomes
      fill(0, 2, O_TMO, 5'd0); fill(2, 1, O_ACK, 5'd2); fill(3, 2, O_TMO, 5'd0);
      run(0, 0, 0, 20'h00400, 5'd4, 0);
      expect_end(V_OK, 6, "R13 timeout budget cleared");
      fill(0, 6, O_DEF, 5'd0); fill(6, 1, O_ACK, 5'd2); fill(7, 6, O_DEF, 5'd0);
      run(0, 0, 0, 20'h00400, 5'd4, 0);
      expect_end(V_OK, 14, "R13 defer budget cleared by ACK");

      // R9 immediate failures, native so no stop
      fill(0, 1, O_NACK, 5'd0);
      run(0, 0, 0, 20'h00500, 5'd1, 0);
      expect_end(V_NACK, 1, "R9 NACK");
      fill(0, 1, O_INACK, 5'd0);
      run(0, 1, 0, 20'h00500, 5'd1, 0);
      expect_end(V_NACK, 1, "R9 I2C NACK");
      fill(0, 1, O_HPD, 5'd0);
      run(0, 0, 0, 20'h00500, 5'd1, 0);
      expect_end(V_HPD, 1, "R9 HPD");

      // R2 R7 R11 I2C write partial ACK, more to come
      fill(0, 1, O_ACK, 5'd2);
      run(1, 1, 1, 20'h000A0, 5'd3, 0);
      chk(r_act[0] == 4'b0100, "R2 I2C write action", r_act[0], 4);
      chk(r_addr[0] == 20'h50, "R2 I2C address shift", r_addr[0], 20'h50);
      chk(r_act[1] == 4'b0110 && r_len[1] == 0, "R7 status poll", r_act[1], 6);
      chk(r_gap[1] >= 302 * CPU && r_gap[1] <= 303 * CPU + 6, "R7 R11 poll wait",
          r_gap[1], 303 * CPU);
      expect_end(V_OK, 2, "R7 partial ACK then done");
      // R7 budget, then stop after failure
      fill(0, 7, O_ACK, 5'd1);
      run(1, 1, 1, 20'h000A0, 5'd3, 0);
      chk(r_act[7] == 4'b0000 && r_len[7] == 0, "R10 stop after failure", r_act[7], 0);
      expect_end(V_TMO, 8, "R7 partial ACK limit");
      // R7 native write ACK with count is success
      fill(0, 1, O_ACK, 5'd2);
      run(0, 1, 0, 20'h00100, 5'd1, 0);
      chk(r_act[0] == 4'b1000, "R2 native write action", r_act[0], 8);
      expect_end(V_OK, 1, "R7 native write ACK");

      // R10 stop on last I2C write, stop outcome ignored
      fill(0, 1, O_ACK, 5'd0); fill(1, 1, O_NACK, 5'd0);
      run(1, 1, 0, 20'h000A0, 5'd1, 0);
      chk(r_act[1] == 4'b0000 && r_addr[1] == 20'h50, "R10 write stop", r_act[1], 0);
      expect_end(V_OK, 2, "R10 stop outcome ignored");
      fill(0, 1, O_NACK, 5'd0);
      run(1, 0, 1, 20'h000A0, 5'd1, 0);
      chk(r_act[0] == 4'b0101 && r_act[1] == 4'b0001, "R10 read stop after NACK", r_act[1], 1);
      expect_end(V_NACK, 2, "R10 failed I2C read");

      // R8 R5 I2C write defer sweep (limit 8)
      for (int n = 8; n <= 9; n++) begin
         fill(0, n, O_IDEF, 5'd0);
         run(1, 1, 1, 20'h000A0, 5'd2, 0);
         chk(r_act[1] == 4'b0110 && r_len[1] == 0, "R8 defer becomes poll", r_act[1], 6);
         chk(r_gap[1] >= (GAP - 1) * CPU && r_gap[1] <= GAP * CPU + 6, "R11 I2C gap",
             r_gap[1], GAP * CPU);
         if (n == 8) expect_end(V_OK, 9, "R8 write I2C defers");
         else        expect_end(V_TMO, 10, "R8 write I2C defer limit");
      end
      // R5 I2C read defer limit
      for (int n = 6; n <= 7; n++) begin
         fill(0, n, O_IDEF, 5'd0);
         run(1, 0, 1, 20'h000A0, 5'd1, 0);
         if (n == 6) expect_end(V_OK, 7, "R5 read I2C defers");
         else        expect_end(V_TMO, 8, "R5 read I2C defer limit");
      end
      // R8 I2C defer clears AUX defer budget
      fill(0, 6, O_DEF, 5'd0); fill(6, 1, O_IDEF, 5'd0); fill(7, 6, O_DEF, 5'd0);
      run(1, 0, 1, 20'h000A0, 5'd1, 0);
      expect_end(V_OK, 14, "R8 AUX defer cleared");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule